// File: doc/BRIEF.md
# Load Address Generation Unit

This unit turns the operand fields of a load instruction into a memory request, a base-register update and a loaded result. The base can be a register value or a long-immediate literal. The offset is a 9-bit signed value, given as a separate sign bit and eight low bits. A 2-bit addressing mode chooses how the offset is applied:

- offset added before the access,
- offset added before the access with the base written back,
- the unmodified base used for the access and then incremented,
- the offset scaled by the access size.

A 2-bit size code and a sign-extend bit set the access width and how the returned data is widened.

Control is a two-state machine. In `ST_IDLE` an incoming request is decoded in the same cycle. A legal request raises the memory read strobe and, in a writeback mode, the base writeback, and then takes the transition `IDLE->FETCH`. In `ST_FETCH` the memory port returns the data. The data is zero- or sign-extended and presented on the destination write port, and the transition `FETCH->IDLE` is taken unconditionally. An illegal request raises only the illegal flag and takes the transition `IDLE->IDLE`, the same as no request. The block is busy in `ST_FETCH` and ignores requests there.

Top module: `ld_agu`

## Requirements
- R1: The offset equals the eight low bits minus 256 when the sign bit is set, and equals the eight low bits otherwise, sign-extended to 32 bits.
- R2: Address modes 0 and 1 drive `mem_addr` with base plus offset.
- R3: Address mode 2 drives `mem_addr` with the unmodified base.
- R4: Address mode 3 drives `mem_addr` with base plus offset times 4 for size code 0, and with base plus offset times 2 for size code 2.
- R5: Modes 1 and 2 raise `wb_base_en` with `wb_base_val` equal to base plus the unscaled offset. Modes 0 and 3 never raise it.
- R6: When `use_limm` is set, `limm_val` is the base and `insn_len` is 8. Otherwise `base_val` is the base and `insn_len` is 4. `insn_len` is 0 when no request is accepted.
- R7: A request is illegal when any of these holds:
  - size code is 3,
  - size code is 1 with mode 3,
  - `sext` is set with size code 0,
  - `use_limm` is set with mode 1 or 2.
- R8: An illegal request raises `illegal` in the same cycle. It suppresses `mem_rd` and `wb_base_en`, and no `wb_dst_en` follows in the next cycle.
- R9: `mem_size` repeats the size code: 0 means 32-bit, 1 means 8-bit, 2 means 16-bit.
- R10: One cycle after `mem_rd`, `wb_dst_en` is high. `wb_dst_val` is `mem_rdata` for size 0. For size 1 it is the low 8 bits and for size 2 the low 16 bits, each zero-extended, or sign-extended when `sext` was set.
- R11: A request presented in the cycle after an accepted load is ignored. `mem_rd`, `wb_base_en`, `illegal` and `insn_len` all stay 0.
- R12: After reset the block is idle, and `mem_rd`, `wb_dst_en`, `wb_base_en`, `illegal` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| base_val | input | 32 | Base register value |
| use_limm | input | 1 | Use the literal as base |
| limm_val | input | 32 | Long-immediate literal |
| ofs_sign | input | 1 | Offset sign bit |
| ofs_low | input | 8 | Offset low bits |
| amode | input | 2 | Addressing mode |
| dsize | input | 2 | Size code |
| sext | input | 1 | Sign-extend request |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | Access size code |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_rd` |
| wb_base_en | output | 1 | Base register writeback enable |
| wb_base_val | output | 32 | Updated base value |
| wb_dst_en | output | 1 | Destination writeback enable |
| wb_dst_val | output | 32 | Extended load result |
| illegal | output | 1 | Illegal instruction flag |
| insn_len | output | 4 | Instruction length in bytes |
| busy | output | 1 | Waiting for read data |

## Verification
A stuck or wrongly entered `ST_FETCH` shows up one cycle after issue in one of two ways. Either `wb_dst_en` is missing, or the block accepts a second request in the busy cycle, with `mem_rd` or `insn_len` nonzero. A wrongly captured size or extend control surfaces in the same following cycle, as wrong upper bits on `wb_dst_val`. Address, length and legality faults are combinational and visible in the issue cycle itself. A leak of an illegal request into the memory strobe or either writeback appears within at most one cycle.

// File: rtl/ld_agu_pkg.sv
package ld_agu_pkg;
    typedef enum logic [1:0] {
        SZ_WORD = 2'd0,
        SZ_BYTE = 2'd1,
        SZ_HALF = 2'd2,
        SZ_BAD  = 2'd3
    } dsize_e;

    typedef enum logic [1:0] {
        AM_OFS    = 2'd0,
        AM_PRE_WB = 2'd1,
        AM_POST   = 2'd2,
        AM_SCALED = 2'd3
    } amode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } state_e;
endpackage

// File: rtl/ld_agu_decode.sv
module ld_agu_decode
    import ld_agu_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int OFS_LO_W = 8
) (
    input  logic [XLEN-1:0]     base_val,
    input  logic                use_limm,
    input  logic [XLEN-1:0]     limm_val,
    input  logic                ofs_sign,
    input  logic [OFS_LO_W-1:0] ofs_low,
    input  amode_e              am,
    input  dsize_e              sz,
    input  logic                sext,
    output logic [XLEN-1:0]     eff_addr,
    output logic [XLEN-1:0]     upd_val,
    output logic                upd_mode,
    output logic                bad,
    output logic                len8
);
    localparam int OFS_W = OFS_LO_W + 1;

    logic [XLEN-1:0] base_sel;
    logic [XLEN-1:0] ofs_x;
    logic [XLEN-1:0] ofs_scaled;

    // R1: sign bit stacked on the low bits is a two's complement value
    assign ofs_x    = {{(XLEN-OFS_W){ofs_sign}}, ofs_sign, ofs_low};
    assign base_sel = use_limm ? limm_val : base_val;
    assign len8     = use_limm;
    assign upd_val  = base_sel + ofs_x;
    assign upd_mode = (am == AM_PRE_WB) || (am == AM_POST);

    always_comb begin
        ofs_scaled = ofs_x;
        if (sz == SZ_WORD)
            ofs_scaled = ofs_x << 2;
        else if (sz == SZ_HALF)
            ofs_scaled = ofs_x << 1;
    end

    always_comb begin
        unique case (am)
            AM_OFS, AM_PRE_WB: eff_addr = base_sel + ofs_x;
            AM_POST:           eff_addr = base_sel;
            AM_SCALED:         eff_addr = base_sel + ofs_scaled;
            default:           eff_addr = base_sel;
        endcase
    end

    always_comb begin
        bad = 1'b0;
        if (sz == SZ_BAD)                       bad = 1'b1;
        if (am == AM_SCALED && sz == SZ_BYTE)   bad = 1'b1;
        if (sext && sz == SZ_WORD)              bad = 1'b1;
        if (use_limm && upd_mode)               bad = 1'b1;
    end
endmodule

// File: rtl/ld_agu_extend.sv
module ld_agu_extend
    import ld_agu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] raw,
    input  dsize_e          sz,
    input  logic            sext,
    output logic [XLEN-1:0] val
);
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    always_comb begin
        unique case (sz)
            SZ_BYTE: val = {{(XLEN-BYTE_W){sext & raw[BYTE_W-1]}}, raw[BYTE_W-1:0]};
            SZ_HALF: val = {{(XLEN-HALF_W){sext & raw[HALF_W-1]}}, raw[HALF_W-1:0]};
            default: val = raw;
        endcase
    end

    // R10
    always_comb begin
        if (sz == SZ_BYTE && !sext)
            zero_ext_byte_chk: assert (val[XLEN-1:BYTE_W] == '0);
    end
endmodule

// File: rtl/ld_agu.sv
module ld_agu
    import ld_agu_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int OFS_LO_W = 8,
    parameter int LEN_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [XLEN-1:0]     base_val,
    input  logic                use_limm,
    input  logic [XLEN-1:0]     limm_val,
    input  logic                ofs_sign,
    input  logic [OFS_LO_W-1:0] ofs_low,
    input  logic [1:0]          amode,
    input  logic [1:0]          dsize,
    input  logic                sext,
    output logic                mem_rd,
    output logic [XLEN-1:0]     mem_addr,
    output logic [1:0]          mem_size,
    input  logic [XLEN-1:0]     mem_rdata,
    output logic                wb_base_en,
    output logic [XLEN-1:0]     wb_base_val,
    output logic                wb_dst_en,
    output logic [XLEN-1:0]     wb_dst_val,
    output logic                illegal,
    output logic [LEN_W-1:0]    insn_len,
    output logic                busy
);
    localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(4);
    localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(8);

    state_e          state_q, state_d;
    dsize_e          cap_sz_q;
    logic            cap_sext_q;
    logic            issue;
    logic [XLEN-1:0] eff_addr, upd_val;
    logic            upd_mode, bad, len8;

    ld_agu_decode #(.XLEN(XLEN), .OFS_LO_W(OFS_LO_W)) u_dec (
        .base_val (base_val),
        .use_limm (use_limm),
        .limm_val (limm_val),
        .ofs_sign (ofs_sign),
        .ofs_low  (ofs_low),
        .am       (amode_e'(amode)),
        .sz       (dsize_e'(dsize)),
        .sext     (sext),
        .eff_addr (eff_addr),
        .upd_val  (upd_val),
        .upd_mode (upd_mode),
        .bad      (bad),
        .len8     (len8)
    );

    ld_agu_extend #(.XLEN(XLEN)) u_ext (
        .raw  (mem_rdata),
        .sz   (cap_sz_q),
        .sext (cap_sext_q),
        .val  (wb_dst_val)
    );

    assign issue = req_valid && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (issue && !bad) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cap_sz_q   <= SZ_WORD;
            cap_sext_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (issue && !bad) begin
                cap_sz_q   <= dsize_e'(dsize);
                cap_sext_q <= sext;
            end
        end
    end

    always_comb begin
        mem_rd      = issue && !bad;
        mem_addr    = eff_addr;
        mem_size    = dsize;
        illegal     = issue && bad;
        wb_base_en  = issue && !bad && upd_mode;
        wb_base_val = upd_val;
        insn_len    = issue ? (len8 ? LEN_LONG : LEN_SHORT) : '0;
        wb_dst_en   = (state_q == ST_FETCH);
        busy        = (state_q == ST_FETCH);
    end

    // R10
    dst_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_dst_en |-> $past(mem_rd));
    // R11
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (!mem_rd && !wb_base_en && !illegal));
    // R8
    illegal_no_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> !wb_dst_en);
    // R5
    wb_no_limm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_base_en |-> !use_limm);
    // R3
    post_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && amode == 2'd2) |-> (mem_addr == base_val));
    // R6
    long_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && use_limm) |-> (insn_len == LEN_LONG));
endmodule

// File: tb/ld_agu_test.sv
module ld_agu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] base_val = '0;
    logic        use_limm = 1'b0;
    logic [31:0] limm_val = '0;
    logic        ofs_sign = 1'b0;
    logic [7:0]  ofs_low = '0;
    logic [1:0]  amode = '0;
    logic [1:0]  dsize = '0;
    logic        sext = 1'b0;
    logic        mem_rd;
    logic [31:0] mem_addr;
    logic [1:0]  mem_size;
    logic [31:0] mem_rdata = '0;
    logic        wb_base_en;
    logic [31:0] wb_base_val;
    logic        wb_dst_en;
    logic [31:0] wb_dst_val;
    logic        illegal;
    logic [3:0]  insn_len;
    logic        busy;

    int checks = 0;
    int errors = 0;

    ld_agu uut (.*);

    always #5 clk = ~clk;

    function automatic logic [31:0] mem_fn(logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= mem_fn(mem_addr);

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired, actual hang expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] e_ofs(logic s, logic [7:0] lo);
        int v = s ? int'(lo) - 256 : int'(lo);
        return 32'(v);
    endfunction

    function automatic logic e_bad(logic l, logic [1:0] m, logic [1:0] z, logic x);
        return (z == 2'd3) || (m == 2'd3 && z == 2'd1) || (x && z == 2'd0) ||
               (l && (m == 2'd1 || m == 2'd2));
    endfunction

    function automatic logic [31:0] e_ext(logic [31:0] d, logic [1:0] z, logic x);
        if (z == 2'd1) return x ? {{24{d[7]}}, d[7:0]} : {24'h0, d[7:0]};
        if (z == 2'd2) return x ? {{16{d[15]}}, d[15:0]} : {16'h0, d[15:0]};
        return d;
    endfunction

    task automatic run_op(logic [31:0] b, logic l, logic [31:0] lv, logic s,
                          logic [7:0] lo, logic [1:0] m, logic [1:0] z, logic x);
        logic [31:0] base, o, addr;
        logic bad;
        base = l ? lv : b;
        o    = e_ofs(s, lo);
        bad  = e_bad(l, m, z, x);
        if (m == 2'd2) addr = base;
        else if (m == 2'd3 && z == 2'd0) addr = base + (o << 2);
        else if (m == 2'd3 && z == 2'd2) addr = base + (o << 1);
        else addr = base + o;
        @(negedge clk);
        req_valid = 1'b1; base_val = b; use_limm = l; limm_val = lv;
        ofs_sign = s; ofs_low = lo; amode = m; dsize = z; sext = x;
        #1;
        check("R7 R8 illegal", 32'(illegal), 32'(bad));
        check("R8 mem_rd", 32'(mem_rd), 32'(!bad));
        check("R6 insn_len", 32'(insn_len), l ? 32'd8 : 32'd4);
        check("R5 wb_base_en", 32'(wb_base_en), 32'(!bad && (m == 2'd1 || m == 2'd2)));
        if (!bad) begin
            check("R1 R2 R3 R4 mem_addr", mem_addr, addr);
            check("R9 mem_size", 32'(mem_size), 32'(z));
            if (m == 2'd1 || m == 2'd2) check("R5 wb_base_val", wb_base_val, base + o);
        end
        @(negedge clk);
        if (bad) begin
            req_valid = 1'b0;
            #1;
            check("R8 no dst", 32'(wb_dst_en), 32'd0);
        end else begin
            req_valid = 1'b1; base_val = $urandom; amode = 2'd1; dsize = 2'd0;
            use_limm = 1'b0; sext = 1'b0;
            #1;
            check("R11 busy", 32'(busy), 32'd1);
            check("R11 ignored rd", 32'(mem_rd), 32'd0);
            check("R11 ignored wb", 32'(wb_base_en), 32'd0);
            check("R11 ignored len", 32'(insn_len), 32'd0);
            check("R10 dst_en", 32'(wb_dst_en), 32'd1);
            check("R10 dst_val", wb_dst_val, e_ext(mem_fn(addr), z, x));
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        #1;
        check("R12 mem_rd", 32'(mem_rd), 32'd0);
        check("R12 wb_dst_en", 32'(wb_dst_en), 32'd0);
        check("R12 busy", 32'(busy), 32'd0);
        check("R12 illegal", 32'(illegal), 32'd0);
        check("R12 wb_base_en", 32'(wb_base_en), 32'd0);
        rst_n = 1'b1;
        // directed corner cases
        run_op(32'h1000, 0, 0, 1, 8'h00, 2'd0, 2'd0, 0); // R1 offset -256
        run_op(32'h1000, 0, 0, 0, 8'hFF, 2'd1, 2'd0, 0); // R1 R5 offset +255
        run_op(32'h2000, 0, 0, 1, 8'hFF, 2'd2, 2'd2, 1); // R3 post, -1
        run_op(32'h3000, 0, 0, 1, 8'hFE, 2'd3, 2'd0, 0); // R4 word scale
        run_op(32'h3000, 0, 0, 0, 8'h10, 2'd3, 2'd2, 0); // R4 half scale
        run_op(32'h0, 1, 32'h8000_0080, 0, 8'h00, 2'd0, 2'd1, 1); // R6 R10 sign byte
        run_op(32'h0, 1, 32'h8000_0080, 0, 8'h00, 2'd0, 2'd1, 0); // R10 zero byte
        run_op(32'h10, 0, 0, 0, 8'h01, 2'd3, 2'd1, 0); // R7 byte scaled
        run_op(32'h10, 0, 0, 0, 8'h01, 2'd0, 2'd3, 0); // R7 size 3
        run_op(32'h10, 0, 0, 0, 8'h01, 2'd0, 2'd0, 1); // R7 sext word
        run_op(32'h10, 1, 32'h44, 0, 8'h01, 2'd1, 2'd0, 0); // R7 limm writeback
        run_op(32'h10, 1, 32'h44, 0, 8'h01, 2'd2, 2'd2, 0); // R7 limm post
        for (int i = 0; i < 400; i++)
            run_op($urandom, ($urandom % 4) == 0, $urandom, 1'($urandom),
                   8'($urandom), 2'($urandom), 2'($urandom), 1'($urandom));
        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule